// File: doc/BRIEF.md
# Four-Sector Hit Word Merger with Byte Output

This block collects 16-bit hit words coming from four independent sector encoders, holds each sector's words in its own first-in first-out buffer of 48 entries, and merges them into one byte stream for a downstream 8-bit line-coding stage. All buffers and the merge logic run in one clock domain.

A control state machine picks a sector whose buffer holds data, round-robin starting after the sector it served last, removes one word and presents it as two consecutive bytes, high byte first. The output uses a valid/ready handshake. When no buffer holds data, the output carries a fixed idle byte with valid low. A write into a full buffer is discarded and raises a sticky per-sector overflow flag that a clear input resets.

Top module: `sector_merge_top`

## Requirements
- R1: Each sector buffer stores up to 48 words; `sect_full[i]` is 1 exactly while buffer i holds 48 words, and a write to a non-full buffer is accepted and later delivered.
- R2: A write to a full buffer is discarded (never delivered) and sets `ovf_flag[i]` one cycle later; the flag stays set until cleared.
- R3: `ovf_clr` high for one cycle clears all overflow flags on the next edge; if a write hits a full buffer in that same cycle, that sector's flag stays set.
- R4: Each word leaves as two accepted bytes in a row, bits 15:8 first and bits 7:0 second, with no byte of another word between them.
- R5: Sectors are served round-robin among non-empty buffers, starting at the sector after the one served last; after reset sector 0 has first priority.
- R6: While `out_valid` is 0, `out_byte` equals the idle value 8'h5A.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_byte` does not change.
- R8: A word written into empty buffers while the merger is idle shows its high byte one cycle after the write edge; with `out_ready` held high, stored words leave back to back with one byte per cycle.
- R9: `sect_empty[i]` is 1 exactly while buffer i holds no words.
- R10: After reset all buffers are empty, no overflow flag is set and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for buffers and merger |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 4 | Per-sector write strobe |
| wr_word | input | 64 | Per-sector 16-bit words, sector i in bits 16i+15:16i |
| ovf_clr | input | 1 | Clears all overflow flags |
| sect_full | output | 4 | Buffer i holds 48 words |
| sect_empty | output | 4 | Buffer i holds no words |
| ovf_flag | output | 4 | Sticky overflow flag per sector |
| out_byte | output | 8 | Output byte, idle value 8'h5A when not valid |
| out_valid | output | 1 | out_byte carries data |
| out_ready | input | 1 | Downstream accepts the byte |

## Verification
On every cycle the assertions check the idle byte, the hold of a stalled byte, that a high byte is always followed by its low byte, that at most one buffer is read at a time and never an empty one, and the set, hold and clear rules of the overflow flags. Only the bench scenarios can show the actual word order across sectors under round-robin, that the pointer starts from the last served sector, the exact capacity at which writes begin to be dropped, the one-cycle latency and the absence of bubbles in a long drain.

// File: rtl/sector_merge_pkg.sv
package sector_merge_pkg;
    localparam int NUM_SECT   = 4;
    localparam int WORD_W     = 16;
    localparam int BYTE_W     = 8;
    localparam int SECT_W     = $clog2(NUM_SECT);
    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'h5A;

    typedef enum logic [1:0] {
        SND_IDLE = 2'd0,
        SND_HI   = 2'd1,
        SND_LO   = 2'd2
    } snd_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } hit_word_t;

    // Round-robin choice: nearest requesting sector after 'last'; 'last' itself lowest.
    function automatic logic [SECT_W-1:0] rr_next(
        input logic [NUM_SECT-1:0] req,
        input logic [SECT_W-1:0]   last
    );
        logic [SECT_W-1:0] idx;
        rr_next = last;
        for (int k = NUM_SECT; k >= 1; k--) begin
            idx = SECT_W'((int'(last) + k) % NUM_SECT);
            if (req[idx]) rr_next = idx;
        end
    endfunction
endpackage

// File: rtl/sector_fifo.sv
module sector_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    input  logic         ovf_clr,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    output logic         ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
            if (push && full)  ovf <= 1'b1;
            else if (ovf_clr)  ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter
    import sector_merge_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SECT-1:0] req,
    input  logic                advance,
    output logic [SECT_W-1:0]   gnt_idx,
    output logic                any_req
);
    logic [SECT_W-1:0] last_q;

    assign any_req = |req;
    assign gnt_idx = rr_next(req, last_q);

    always_ff @(posedge clk) begin
        if (rst)          last_q <= SECT_W'(NUM_SECT - 1);
        else if (advance) last_q <= gnt_idx;
    end
endmodule

// File: rtl/byte_sender.sv
module byte_sender
    import sector_merge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              any_req,
    input  hit_word_t         word_in,
    input  logic              out_ready,
    output logic              take,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_valid,
    output logic              phase_lo
);
    snd_state_e state_q;
    hit_word_t  word_q;

    always_comb begin
        take = 1'b0;
        case (state_q)
            SND_IDLE: take = any_req;
            SND_LO:   take = out_ready && any_req;
            default:  take = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SND_IDLE;
            word_q  <= '0;
        end else begin
            if (take) word_q <= word_in;
            case (state_q)
                SND_IDLE: if (any_req)   state_q <= SND_HI;
                SND_HI:   if (out_ready) state_q <= SND_LO;
                SND_LO:   if (out_ready) state_q <= any_req ? SND_HI : SND_IDLE;
                default:                 state_q <= SND_IDLE;
            endcase
        end
    end

    assign out_valid = (state_q == SND_HI) || (state_q == SND_LO);
    assign phase_lo  = (state_q == SND_LO);

    always_comb begin
        case (state_q)
            SND_HI:  out_byte = word_q.hi;
            SND_LO:  out_byte = word_q.lo;
            default: out_byte = IDLE_BYTE;
        endcase
    end
endmodule

// File: rtl/sector_merge_top.sv
module sector_merge_top
    import sector_merge_pkg::*;
#(
    parameter int DEPTH = 48
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_SECT-1:0]        wr_valid,
    input  logic [NUM_SECT*WORD_W-1:0] wr_word,
    input  logic                       ovf_clr,
    output logic [NUM_SECT-1:0]        sect_full,
    output logic [NUM_SECT-1:0]        sect_empty,
    output logic [NUM_SECT-1:0]        ovf_flag,
    output logic [BYTE_W-1:0]          out_byte,
    output logic                       out_valid,
    input  logic                       out_ready
);
    logic [WORD_W-1:0]   head [NUM_SECT];
    logic [NUM_SECT-1:0] fifo_pop;
    logic [SECT_W-1:0]   gnt_idx;
    logic                any_req, take, phase_lo;
    hit_word_t           sel_word;

    for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
        sector_fifo #(.W(WORD_W), .DEPTH(DEPTH)) fifo_i (
            .clk       (clk),
            .rst       (rst),
            .push      (wr_valid[s]),
            .push_data (wr_word[s*WORD_W +: WORD_W]),
            .pop       (fifo_pop[s]),
            .ovf_clr   (ovf_clr),
            .head      (head[s]),
            .empty     (sect_empty[s]),
            .full      (sect_full[s]),
            .ovf       (ovf_flag[s])
        );
        assign fifo_pop[s] = take && (gnt_idx == SECT_W'(s));
    end

    rr_arbiter arb_i (
        .clk     (clk),
        .rst     (rst),
        .req     (~sect_empty),
        .advance (take),
        .gnt_idx (gnt_idx),
        .any_req (any_req)
    );

    assign sel_word = hit_word_t'(head[gnt_idx]);

    byte_sender snd_i (
        .clk       (clk),
        .rst       (rst),
        .any_req   (any_req),
        .word_in   (sel_word),
        .out_ready (out_ready),
        .take      (take),
        .out_byte  (out_byte),
        .out_valid (out_valid),
        .phase_lo  (phase_lo)
    );
endmodule

// File: rtl/sector_merge_chk.sv
module sector_merge_chk
    import sector_merge_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [NUM_SECT-1:0] wr_valid,
    input logic [NUM_SECT-1:0] sect_full,
    input logic [NUM_SECT-1:0] sect_empty,
    input logic [NUM_SECT-1:0] ovf_flag,
    input logic                ovf_clr,
    input logic [BYTE_W-1:0]   out_byte,
    input logic                out_valid,
    input logic                out_ready,
    input logic                phase_lo,
    input logic [NUM_SECT-1:0] fifo_pop
);
    logic [NUM_SECT-1:0] hit_full;
    assign hit_full = wr_valid & sect_full;

    a_r6_idle_byte: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> out_byte == IDLE_BYTE);

    a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(phase_lo));

    a_r4_low_follows: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !phase_lo |=> out_valid && phase_lo);

    a_r2_ovf_set: assert property (@(posedge clk) disable iff (rst)
        hit_full != '0 |=> (ovf_flag & $past(hit_full)) == $past(hit_full));

    a_r2_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        !ovf_clr |=> (ovf_flag & $past(ovf_flag)) == $past(ovf_flag));

    a_r3_ovf_clear: assert property (@(posedge clk) disable iff (rst)
        ovf_clr && hit_full == '0 |=> ovf_flag == '0);

    a_r5_single_pop: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fifo_pop) && ((fifo_pop & sect_empty) == '0));
endmodule

bind sector_merge_top sector_merge_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .wr_valid   (wr_valid),
    .sect_full  (sect_full),
    .sect_empty (sect_empty),
    .ovf_flag   (ovf_flag),
    .ovf_clr    (ovf_clr),
    .out_byte   (out_byte),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .phase_lo   (phase_lo),
    .fifo_pop   (fifo_pop)
);

// File: tb/sector_merge_top_tb_top.sv
`timescale 1ns/1ps
module sector_merge_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  wr_valid;
    logic [63:0] wr_word;
    logic        ovf_clr;
    logic [3:0]  sect_full, sect_empty, ovf_flag;
    logic [7:0]  out_byte;
    logic        out_valid;
    logic        out_ready;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q [$];
    logic       stall_seen = 1'b0;
    logic [7:0] stall_byte = '0;
    int         cyc = 0;

    always #2.5 clk = ~clk;

    sector_merge_top dut_i (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_word(wr_word),
        .ovf_clr(ovf_clr), .sect_full(sect_full), .sect_empty(sect_empty),
        .ovf_flag(ovf_flag), .out_byte(out_byte), .out_valid(out_valid),
        .out_ready(out_ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_word(input logic [15:0] w);
        exp_q.push_back(w[15:8]);
        exp_q.push_back(w[7:0]);
    endtask

    // Drives one write cycle; caller is never at a clock edge.
    task automatic write_cycle(input logic [3:0] mask, input logic [15:0] w0,
                               input logic [15:0] w1, input logic [15:0] w2,
                               input logic [15:0] w3, input logic clr);
        wr_valid = mask;
        wr_word  = {w3, w2, w1, w0};
        ovf_clr  = clr;
        @(posedge clk); #1;
        wr_valid = '0;
        ovf_clr  = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic wait_drain();
        int t = 0;
        while (exp_q.size() != 0 && t < 2000) begin
            @(posedge clk); #1;
            t++;
        end
        idle_cycles(2);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Scoreboard monitor: compares every accepted byte, and stall hold (R7).
    always @(negedge clk) begin
        if (!rst) begin
            if (stall_seen) begin
                check(out_valid && out_byte == stall_byte, "R7 stalled byte held",
                      int'(out_byte), int'(stall_byte));
            end
            stall_seen = out_valid && !out_ready;
            stall_byte = out_byte;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 R5 unexpected byte", int'(out_byte), 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(out_byte == e, "R4 R5 byte order", int'(out_byte), int'(e));
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
            finish_run();
        end
    end

    initial begin
        int n;
        rst = 1'b1; wr_valid = '0; wr_word = '0; ovf_clr = 1'b0; out_ready = 1'b1;
        idle_cycles(3);
        rst = 1'b0;
        idle_cycles(1);

        // R10 / R6 reset state
        @(negedge clk);
        check(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
        check(sect_empty == 4'hF && sect_full == 4'h0, "R10 buffers empty", sect_empty, 4'hF);
        check(ovf_flag == 4'h0, "R10 no overflow", ovf_flag, 0);
        check(out_byte == 8'h5A, "R6 idle byte", out_byte, 8'h5A);

        // R8 latency, R9 status, single sector
        expect_word(16'hA1B2);
        write_cycle(4'b0100, 0, 0, 16'hA1B2, 0, 1'b0);
        @(negedge clk);
        check(out_valid == 1'b0, "R8 not valid on write edge", out_valid, 0);
        check(sect_empty == 4'b1011, "R9 sector 2 not empty", sect_empty, 4'b1011);
        @(negedge clk);
        check(out_valid && out_byte == 8'hA1, "R8 high byte one cycle later", out_byte, 8'hA1);
        wait_drain();

        // R5 round-robin, last served is sector 2, so sector 3 first; R7 stalls
        out_ready = 1'b0;
        expect_word(16'h4444); expect_word(16'h1111);
        expect_word(16'h2222); expect_word(16'h3333);
        expect_word(16'h8888); expect_word(16'h5555);
        expect_word(16'h6666); expect_word(16'h7777);
        write_cycle(4'hF, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 1'b0);
        write_cycle(4'hF, 16'h5555, 16'h6666, 16'h7777, 16'h8888, 1'b0);
        for (int i = 0; i < 30; i++) begin
            out_ready = (i % 3) != 0;
            @(posedge clk); #1;
        end
        out_ready = 1'b1;
        wait_drain();

        // R5 start after last served (sector 2): sector 3 before sector 1
        expect_word(16'hD3D4); expect_word(16'hC1C2);
        write_cycle(4'b1010, 0, 16'hC1C2, 0, 16'hD3D4, 1'b0);
        wait_drain();

        // R6 idle again
        @(negedge clk);
        check(!out_valid && out_byte == 8'h5A, "R6 idle after drain", out_byte, 8'h5A);
        check(sect_empty == 4'hF, "R9 all empty after drain", sect_empty, 4'hF);

        // R1 / R2 capacity and overflow on sector 0 with output stalled
        out_ready = 1'b0;
        for (int i = 0; i < 49; i++) begin
            expect_word(16'h0100 + 16'(i));
            write_cycle(4'b0001, 16'h0100 + 16'(i), 0, 0, 0, 1'b0);
        end
        check(sect_full == 4'b0001, "R1 full after 48 stored", sect_full, 4'b0001);
        check(ovf_flag == 4'h0, "R1 no overflow at capacity", ovf_flag, 0);
        write_cycle(4'b0001, 16'hDEAD, 0, 0, 0, 1'b0);
        check(ovf_flag == 4'b0001, "R2 overflow flag set", ovf_flag, 4'b0001);
        idle_cycles(3);
        check(ovf_flag == 4'b0001, "R2 overflow flag sticky", ovf_flag, 4'b0001);

        // R3 clear with concurrent overflow keeps flag, then plain clear
        write_cycle(4'b0001, 16'hBEEF, 0, 0, 0, 1'b1);
        check(ovf_flag == 4'b0001, "R3 set wins over clear", ovf_flag, 4'b0001);
        write_cycle(4'b0000, 0, 0, 0, 0, 1'b1);
        check(ovf_flag == 4'h0, "R3 clear resets flags", ovf_flag, 0);

        // R8 back-to-back drain of 49 words = 98 bytes
        out_ready = 1'b1;
        n = 0;
        @(negedge clk);
        while (out_valid && n < 200) begin
            n++;
            @(negedge clk);
        end
        check(n == 98, "R8 no bubbles in drain", n, 98);
        check(exp_q.size() == 0, "R2 dropped words never sent", exp_q.size(), 0);
        check(sect_empty == 4'hF, "R9 empty after overflow drain", sect_empty, 4'hF);

        finish_run();
    end
endmodule